// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block passes an 18-bit word between two ports, A and B, one storage element for each direction. The A-to-B element is controlled by its own latch-enable, clock and output-enable inputs, and the B-to-A element has a matching set. Each element works in one of three ways:

- **Transparent:** while its latch-enable is high, the output follows the input.
- **Hold:** while its latch-enable is low and its clock is steady, it keeps its value.
- **Capture:** while its latch-enable is low, it takes a new value when its clock falls.

All data paths are non-inverting. The two output enables have opposite polarity:

- The A-to-B enable is active high.
- The B-to-A enable is active low.

The block runs on a system clock `clk`. The control clocks `ab_cp` and `ba_cp` are sampled on `clk`, and a falling edge is seen when two consecutive samples read high and then low. Tri-state pads are modelled as a data output plus an output-enable flag for each port. Each port has a bus-hold register. When no external driver is present (`*_ext_drive` low), the input path reads the held value. The hold register reloads every cycle from whatever is on the bus: the block's own output when the block drives that port, otherwise the external data.

Power-up reset is the asynchronous active-low input `rst_n`. It clears both storage elements and both hold registers. It keeps both output enables inactive until the first `clk` edge after release. Data on this block is level-based and always accepted. It has no valid/ready handshake and applies no back-pressure.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While `rst_n` is low, `b_out_en` and `a_out_en` are 0 and `b_out`, `a_out` are 0 (with both latch-enables low). Both enables stay 0 until the first rising `clk` edge after release.
- R2: While `ab_le` is 1, `b_out` equals the A-side input word in the same cycle, bit for bit with no inversion, whatever `ab_cp` does.
- R3: When `ab_le` goes from 1 to 0, `b_out` keeps the A-side input sampled at the last `clk` edge with `ab_le` high. It holds that value while `ab_le` stays 0 and `ab_cp` stays steady at either level.
- R4: With `ab_le` 0, a clock edge where `ab_cp` is sampled low after being sampled high at the previous edge loads the A-side input. The new value appears on `b_out` right after that edge. A rise of `ab_cp` changes nothing.
- R5: After reset, `b_out_en` equals `ab_oe` (1 = drive B, 0 = B high-impedance).
- R6: The B-to-A path follows R2 to R4 with `ba_le`, `ba_cp`, the B-side input and `a_out`.
- R7: After reset, `a_out_en` equals the inverse of `ba_oe_n` (0 = drive A).
- R8: The input word of each path is `*_ext_data` when `*_ext_drive` is 1, and otherwise the port's hold register. At each `clk` edge the hold register loads the port's own output if that port's enable is 1, and otherwise loads that input word.
- R9: Each port's enable depends only on its own direction's enable input, so both ports may drive at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| a_ext_data | input | 18 | Value driven onto port A by an external driver |
| a_ext_drive | input | 1 | External driver on port A is active |
| b_ext_data | input | 18 | Value driven onto port B by an external driver |
| b_ext_drive | input | 1 | External driver on port B is active |
| ab_le | input | 1 | A-to-B latch-enable, high = transparent |
| ab_cp | input | 1 | A-to-B capture clock, falling edge active |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch-enable, high = transparent |
| ba_cp | input | 1 | B-to-A capture clock, falling edge active |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Data the block places on port B |
| b_out_en | output | 1 | Block drives port B (0 = high-impedance) |
| a_out | output | 18 | Data the block places on port A |
| a_out_en | output | 1 | Block drives port A (0 = high-impedance) |

## Verification
The assertions assume three things about the inputs:

- Every control and data input changes away from the rising edge of `clk`.
- The capture clocks move slowly enough that each level is seen for at least one `clk` edge.
- No external driver is active on a port while the block drives that same port.

The bench keeps to these rules. It changes every input just after a falling `clk` edge. It holds each capture-clock level for at least one full cycle. It drops the external driver on a port before enabling the block's driver on that port.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W = 18;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_LOAD = 2'd2
  } store_mode_e;
endpackage

// File: rtl/xcvr_hold.sv
module xcvr_hold
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ext_data,
  input  logic         ext_drive,
  input  logic [W-1:0] own_data,
  input  logic         own_drive,
  output logic [W-1:0] rx
);
  logic [W-1:0] hold_q;

  // Input path sees the external driver, or the held level when the bus floats.
  assign rx = ext_drive ? ext_data : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hold_q <= '0;
    else if (own_drive) hold_q <= own_data;
    else                hold_q <= rx;
  end

  // R8
  hold_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_drive && !own_drive) |=> (hold_q == $past(ext_data)));

  // R8
  hold_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_drive |=> (hold_q == $past(own_data)));
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int unsigned W      = XCVR_W,
  parameter bit          OE_LOW = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         cp,
  input  logic         oe_pin,
  output logic [W-1:0] dout,
  output logic         oe
);
  logic         cp_q;
  logic [W-1:0] store_q;
  logic         fall;
  store_mode_e  mode;

  assign fall = cp_q & ~cp;

  always_comb begin
    if (le)        mode = MODE_PASS;
    else if (fall) mode = MODE_LOAD;
    else           mode = MODE_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_q    <= 1'b0;
      store_q <= '0;
    end else begin
      cp_q <= cp;
      if (mode != MODE_HOLD) store_q <= din;
    end
  end

  assign dout = (mode == MODE_PASS) ? din : store_q;

  generate
    if (OE_LOW) begin : g_oe_low
      assign oe = run & ~oe_pin;
    end else begin : g_oe_high
      assign oe = run & oe_pin;
    end
  endgenerate

  // R3
  le_drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le ##1 !le |-> (dout == $past(din)));

  // R4
  fall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && cp_q && !cp) ##1 !le |-> (dout == $past(din)));

  // R3
  steady_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le && !(cp_q && !cp)) ##1 !le |-> $stable(dout));
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W = XCVR_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_ext_data,
  input  logic         a_ext_drive,
  input  logic [W-1:0] b_ext_data,
  input  logic         b_ext_drive,
  input  logic         ab_le,
  input  logic         ab_cp,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_cp,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_out,
  output logic         b_out_en,
  output logic [W-1:0] a_out,
  output logic         a_out_en
);
  logic         run_q;
  logic [W-1:0] a_rx;
  logic [W-1:0] b_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  xcvr_hold #(.W(W)) u_hold_a (
    .clk(clk), .rst_n(rst_n),
    .ext_data(a_ext_data), .ext_drive(a_ext_drive),
    .own_data(a_out), .own_drive(a_out_en),
    .rx(a_rx)
  );

  xcvr_hold #(.W(W)) u_hold_b (
    .clk(clk), .rst_n(rst_n),
    .ext_data(b_ext_data), .ext_drive(b_ext_drive),
    .own_data(b_out), .own_drive(b_out_en),
    .rx(b_rx)
  );

  xcvr_store #(.W(W), .OE_LOW(1'b0)) u_ab (
    .clk(clk), .rst_n(rst_n), .run(run_q),
    .din(a_rx), .le(ab_le), .cp(ab_cp), .oe_pin(ab_oe),
    .dout(b_out), .oe(b_out_en)
  );

  xcvr_store #(.W(W), .OE_LOW(1'b1)) u_ba (
    .clk(clk), .rst_n(rst_n), .run(run_q),
    .din(b_rx), .le(ba_le), .cp(ba_cp), .oe_pin(ba_oe_n),
    .dout(a_out), .oe(a_out_en)
  );

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!b_out_en && !a_out_en);
    end
  end

  // R5
  b_en_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_out_en |-> ab_oe);

  // R7
  a_en_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_out_en |-> !ba_oe_n);
endmodule

// File: tb/bidir_latch_xcvr_test.sv
`timescale 1ns/1ps
module bidir_latch_xcvr_test;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_ext_data = '0;
  logic         a_ext_drive = 1'b0;
  logic [W-1:0] b_ext_data = '0;
  logic         b_ext_drive = 1'b0;
  logic         ab_le = 1'b0, ab_cp = 1'b0, ab_oe = 1'b0;
  logic         ba_le = 1'b0, ba_cp = 1'b0, ba_oe_n = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic         b_out_en, a_out_en;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  bidir_latch_xcvr #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_ext_data(a_ext_data), .a_ext_drive(a_ext_drive),
    .b_ext_data(b_ext_data), .b_ext_drive(b_ext_drive),
    .ab_le(ab_le), .ab_cp(ab_cp), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_cp(ba_cp), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_out_en(b_out_en),
    .a_out(a_out), .a_out_en(a_out_en)
  );

  function automatic logic [W-1:0] pat(input int i);
    return W'((i * 32'h1A2B3) ^ (i << 9) ^ 32'h2A5A5);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    // R1: during reset
    ab_oe = 1'b1; ba_oe_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1", W'(b_out_en), '0);
    chk("R1", W'(a_out_en), '0);
    chk("R1", b_out, '0);
    chk("R1", a_out, '0);
    rst_n = 1'b1;
    #0.5;
    chk("R1", W'(b_out_en), '0);
    chk("R1", W'(a_out_en), '0);
    @(negedge clk);
    // R9: both enables on together
    chk("R9", W'(b_out_en), W'(1));
    chk("R9", W'(a_out_en), W'(1));
    // R5 / R7 polarity
    ab_oe = 1'b0; ba_oe_n = 1'b1; #1;
    chk("R5", W'(b_out_en), '0);
    chk("R7", W'(a_out_en), '0);
    ab_oe = 1'b1; #1;
    chk("R5", W'(b_out_en), W'(1));
    chk("R9", W'(a_out_en), '0);

    // A-to-B: external driver on A, block drives B
    a_ext_drive = 1'b1;
    ab_le = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      a_ext_data = pat(i);
      ab_cp = i[0];
      #1 chk("R2", b_out, pat(i));
    end
    // R3: latch closes, holds last value
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); a_ext_data = pat(100 + i); ab_le = 1'b1;
      tick();
      ab_le = 1'b0; a_ext_data = pat(200 + i); #1;
      chk("R3", b_out, pat(100 + i));
      ab_cp = 1'b1; tick(); chk("R3", b_out, pat(100 + i));
      tick(); chk("R3", b_out, pat(100 + i));
    end
    // R4: falling-edge capture, rising edge ignored
    for (int i = 0; i < 32; i++) begin
      ab_cp = 1'b1; tick();
      held = b_out;
      ab_cp = 1'b0; a_ext_data = pat(300 + i); #1;
      chk("R4", b_out, held);
      tick();
      chk("R4", b_out, pat(300 + i));
      ab_cp = 1'b1; a_ext_data = pat(400 + i); tick();
      chk("R4", b_out, pat(300 + i));
      ab_cp = 1'b0; tick();
      chk("R4", b_out, pat(400 + i));
    end
    // R8: bus-hold on A after external driver leaves
    ab_le = 1'b1;
    for (int i = 0; i < 16; i++) begin
      a_ext_drive = 1'b1; a_ext_data = pat(500 + i); tick();
      a_ext_drive = 1'b0; a_ext_data = ~pat(500 + i); #1;
      chk("R8", b_out, pat(500 + i));
      tick();
      chk("R8", b_out, pat(500 + i));
    end

    // B-to-A: external driver on B, block drives A
    ab_oe = 1'b0; ab_le = 1'b0; tick();
    b_ext_drive = 1'b1; ba_oe_n = 1'b0; ba_le = 1'b1; #1;
    chk("R7", W'(a_out_en), W'(1));
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      b_ext_data = pat(600 + i);
      ba_cp = i[1];
      #1 chk("R6", a_out, pat(600 + i));
    end
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); b_ext_data = pat(700 + i); ba_le = 1'b1;
      tick();
      ba_le = 1'b0; b_ext_data = pat(800 + i); #1;
      chk("R6", a_out, pat(700 + i));
      tick(); chk("R6", a_out, pat(700 + i));
    end
    for (int i = 0; i < 32; i++) begin
      ba_cp = 1'b1; tick();
      ba_cp = 1'b0; b_ext_data = pat(900 + i); tick();
      chk("R6", a_out, pat(900 + i));
      ba_cp = 1'b1; b_ext_data = pat(950 + i); tick();
      chk("R6", a_out, pat(900 + i));
    end
    // R8: block's own drive on A is held after the driver turns off
    a_ext_drive = 1'b0; ab_oe = 1'b0; ab_le = 1'b1; ba_le = 1'b1;
    for (int i = 0; i < 16; i++) begin
      ba_oe_n = 1'b0; b_ext_data = pat(1000 + i); tick();
      ba_oe_n = 1'b1; b_ext_data = ~pat(1000 + i); #1;
      chk("R8", b_out, pat(1000 + i));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule